// File: doc/BRIEF.md
# I2C Target with Byte-Addressed Memory

This block is an I2C target in front of an internal array of 8192 bytes. It is clocked by the system clock and oversamples the bus lines. SCL and SDA pass through a two-stage synchroniser. START and STOP are then found from those samples, and so are the SCL edges. The block drives SDA only through an open-drain enable, and it never drives SCL.

A master selects the block with a 7-bit target address. That address is the fixed code 1010 followed by three strap inputs. The master then sends a 16-bit memory address as two bytes, and after that either writes data or restarts and reads data. Each written byte is stored as soon as it has been received, so a new transaction may begin right away and no ready polling is needed. A write-protect input keeps the array unchanged, but the block still acknowledges the data. An internal pointer advances after every data byte and wraps at the end of the array. A read without an address phase therefore continues from the last position.

Top module: `i2c_byte_mem`

## Requirements
- R1: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Both are recognised from the synchronised samples.
- R2: The first byte after START is a 7-bit target address, MSB first, followed by the R/W bit (0 = write, 1 = read). The block ACKs, pulling SDA low during the ninth SCL clock, only when the address equals binary 1010 followed by strap[2:0]. On a mismatch it does not ACK, and it keeps SDA released until the next START.
- R3: In a write transaction, the two bytes after the target address form a memory address, high byte first. Only the low 13 bits select a location, and the upper 3 bits of the high byte are ignored.
- R4: A STOP ends any operation in progress, releases SDA and returns the block to idle. The address pointer keeps its value.
- R5: A START at any point aborts the current operation, including partly shifted bytes, which are discarded. The block then decodes a new target address.
- R6: Every data byte of a write is ACKed. It is stored at the pointer by the falling SCL edge that follows its eighth bit. There is no busy period, and the byte can be read back in the very next transaction.
- R7: While wp is high, write data bytes are still ACKed, but the array is left unchanged.
- R8: The pointer increments after every data byte, whether read or written, and wraps from 0x1FFF to 0x0000.
- R9: Read data goes out MSB first. Each bit is driven after a falling SCL edge. A read that has no preceding address phase starts at the current pointer.
- R10: During a read, a master ACK after a byte makes the block send the next byte. A master NACK ends the transfer, and SDA stays released until the next START or STOP.
- R11: sda_oe is the only bus output, and a 1 pulls SDA low. It is 0 after reset and rises only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| strap | input | 3 | Low three bits of the target address |
| wp | input | 1 | Write protect, high blocks array writes |
| sda_oe | output | 1 | Open-drain enable, 1 pulls SDA low |

## Verification
Each bus event reaches the logic three system clocks after it happens on the pins: two synchroniser stages plus the stored previous sample. An ACK or a read bit therefore appears on SDA three clocks after the SCL fall that launches it. A stored byte is in place three clocks after the SCL fall that follows its eighth bit. The bench holds each SCL phase for six clocks and samples the line on the last clock before SCL falls, so every result has settled before it is read. Read-back data is compared against a model array, and the expected pointer position is computed from the start address plus the byte count, modulo 8192.

// File: rtl/i2c_byte_mem.sv
module i2c_byte_mem #(
  parameter int         AW       = 13,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap,
  input  logic       wp,
  output logic       sda_oe
);
  localparam int DEPTH = 1 << AW;
  localparam int HW    = AW - 8;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WR, S_RD} st_t;

  logic [1:0] scl_q, sda_q;
  logic       scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_in};
      sda_q <= {sda_q[0], sda_in};
      scl_p <= scl_q[1];
      sda_p <= sda_q[1];
    end

  wire scl   = scl_q[1];
  wire sda   = sda_q[1];
  wire start = scl & scl_p & sda_p & ~sda;
  wire stop  = scl & scl_p & ~sda_p & sda;
  wire rise  = scl & ~scl_p;
  wire fall  = ~scl & scl_p;

  logic [7:0]    mem [DEPTH];
  st_t           st;
  logic [3:0]    cnt;
  logic          ack, rw;
  logic [7:0]    sh;
  logic [AW-1:0] ptr;
  logic [HW-1:0] ahi;

  wire [7:0] rd_byte = mem[ptr];
  wire       match   = (sh[7:1] == {DEV_CODE, strap});
  wire       wr_en   = ~start & ~stop & fall & ~ack & (cnt == 4'd8) & (st == S_WR) & ~wp;

  always_ff @(posedge clk)
    if (wr_en) mem[ptr] <= sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ack <= 1'b0; rw <= 1'b0;
      sh <= '0; ptr <= '0; ahi <= '0; sda_oe <= 1'b0;
    end else if (start) begin
      st <= S_DEV; cnt <= '0; ack <= 1'b0; sda_oe <= 1'b0;
    end else if (stop) begin
      st <= S_IDLE; cnt <= '0; ack <= 1'b0; sda_oe <= 1'b0;
    end else if (st == S_RD) begin
      if (rise) begin
        if (cnt < 4'd8) begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd7) ptr <= ptr + 1'b1;
        end else if (sda) st <= S_IDLE;
        else cnt <= '0;
      end else if (fall)
        sda_oe <= (cnt < 4'd8) ? ~rd_byte[3'd7 - cnt[2:0]] : 1'b0;
    end else if (st != S_IDLE) begin
      if (rise && !ack && cnt < 4'd8) begin
        sh  <= {sh[6:0], sda};
        cnt <= cnt + 4'd1;
      end else if (fall && ack) begin
        ack <= 1'b0; sda_oe <= 1'b0; cnt <= '0;
        case (st)
          S_DEV: if (rw) begin st <= S_RD; sda_oe <= ~rd_byte[7]; end
                 else st <= S_AHI;
          S_AHI: st <= S_ALO;
          S_ALO: st <= S_WR;
          default: ;
        endcase
      end else if (fall && cnt == 4'd8) begin
        if (st == S_DEV && !match) st <= S_IDLE;
        else begin ack <= 1'b1; sda_oe <= 1'b1; end
        case (st)
          S_DEV: rw  <= sh[0];
          S_AHI: ahi <= sh[HW-1:0];
          S_ALO: ptr <= {ahi, sh};
          S_WR:  ptr <= ptr + 1'b1;
          default: ;
        endcase
      end
    end

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (st == S_IDLE && !sda_oe)); // R4
  AST_START_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st == S_DEV && !sda_oe)); // R5
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && st == S_WR && !ack && cnt == 4'd8 && ptr == {AW{1'b1}}) |=> (ptr == '0)); // R8
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl); // R11
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe); // R2
endmodule

// File: tb/tb_i2c_byte_mem.sv
module tb_i2c_byte_mem;
  localparam int Q = 6;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   checks = 0, fails = 0;
  logic [7:0] model [8192];

  always #5 clk = ~clk;

  i2c_byte_mem dut (.clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
                    .strap(STRAP), .wp(wp), .sda_oe(sda_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic i_start;
    sda_m = 1; w(Q); scl_m = 1; w(Q); sda_m = 0; w(Q); scl_m = 0; w(Q);
  endtask

  task automatic i_stop;
    sda_m = 0; w(Q); scl_m = 1; w(Q); sda_m = 1; w(Q);
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    sda_m = b; w(Q); scl_m = 1; w(Q); seen = sda_line; scl_m = 0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit a);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    a = ~s;
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] d);
    logic s;
    for (int i = 0; i < 8; i++) begin clock_bit(1'b1, s); d = {d[6:0], s}; end
    clock_bit(nack, s);
  endtask

  task automatic dev(input bit rd, output bit a);
    send_byte({4'b1010, STRAP, rd}, a);
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
    bit a;
    i_start; dev(0, a); chk(a, "R2 target ack", a, 1);
    send_byte(hi, a); chk(a, {req, " addr hi ack"}, a, 1);
    send_byte(lo, a); chk(a, {req, " addr lo ack"}, a, 1);
  endtask

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'((a * 13 + salt) ^ (a >> 4));
  endfunction

  task automatic write_run(input int base, input int n, input int salt, input logic [7:0] hi_extra);
    bit a;
    set_addr(hi_extra | 8'(base >> 8), 8'(base), "R3");
    for (int i = 0; i < n; i++) begin
      int ad = (base + i) & 16'h1FFF;
      send_byte(pat(ad, salt), a);
      chk(a, wp ? "R7 data ack under wp" : "R6 data ack", a, 1);
      if (!wp) model[ad] = pat(ad, salt);
    end
    i_stop;
  endtask

  task automatic read_cur(input int base, input int n, input string req);
    bit a; logic [7:0] d;
    i_start; dev(1, a); chk(a, "R2 read target ack", a, 1);
    for (int i = 0; i < n; i++) begin
      int ad = (base + i) & 16'h1FFF;
      recv_byte(i == n - 1, d);
      chk(d === model[ad], req, d, model[ad]);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit a; logic s; logic [7:0] d;
    w(5); rst_n = 1; w(5);
    chk(sda_oe == 0, "R11 reset releases sda", sda_oe, 0);

    for (int k = 0; k < 8; k++) begin
      i_start; send_byte({4'b1010, 3'(k), 1'b0}, a);
      chk(a == (k == STRAP), "R2 strap match", a, k == STRAP);
      if (k != STRAP) begin
        send_byte(8'h00, a);
        chk(!a, "R2 released after mismatch", a, 0);
      end
      i_stop;
    end
    i_start; send_byte(8'h5A, a); chk(!a, "R2 wrong code", a, 0); i_stop;

    write_run(16'h1FEC, 40, 1, 8'hE0);
    set_addr(8'h1F, 8'hEC, "R3");
    read_cur(16'h1FEC, 40, "R8 R9 wrapped readback R6");
    i_stop;

    set_addr(8'h00, 8'h05, "R4"); i_stop;
    read_cur(5, 3, "R9 current address read");
    for (int i = 0; i < 3; i++) begin
      clock_bit(1'b1, s); chk(s == 1, "R10 sda released after nack", s, 1);
    end
    i_stop;
    read_cur(8, 1, "R8 pointer advanced past nacked byte R10"); i_stop;

    write_run(16'h0100, 6, 2, 8'h00);
    wp = 1; write_run(16'h0100, 4, 9, 8'h00); wp = 0;
    set_addr(8'h01, 8'h00, "R7");
    read_cur(16'h0100, 4, "R7 wp left array unchanged"); i_stop;

    i_start; dev(0, a); send_byte(8'h00, a); i_stop;
    read_cur(16'h0104, 1, "R4 stop abort kept pointer"); i_stop;

    i_start; dev(0, a); send_byte(8'h01, a);
    for (int i = 0; i < 3; i++) clock_bit(1'b0, s);
    i_start; dev(0, a); chk(a, "R5 restart after partial byte", a, 1);
    send_byte(8'h00, a); send_byte(8'h20, a);
    send_byte(8'hA5, a); chk(a, "R6 data ack", a, 1); model[16'h20] = 8'hA5;
    i_stop;
    set_addr(8'h00, 8'h20, "R5");
    read_cur(16'h20, 1, "R5 write after abort"); i_stop;

    set_addr(8'h00, 8'h30, "R5");
    send_byte(8'h11, a); send_byte(8'h77, a); i_stop;
    model[16'h30] = 8'h11; model[16'h31] = 8'h77;
    set_addr(8'h00, 8'h30, "R5");
    send_byte(8'h22, a); model[16'h30] = 8'h22;
    for (int i = 0; i < 5; i++) clock_bit(1'b0, s);
    i_start; dev(0, a); send_byte(8'h00, a); send_byte(8'h30, a);
    read_cur(16'h30, 2, "R5 partial byte discarded R1"); i_stop;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule